// File: doc/BRIEF.md
# Pseudo-Random Bit Stream Error Detector

This block receives a serial pseudo-random bit stream one bit per enabled clock and aligns a local sequence generator to it. It first fills the generator from the incoming bits and then demands a run of correct predictions. Once it is aligned, it compares each received bit with the locally predicted bit. Each mismatch is sorted into one of two categories: a 1 that arrived where a 0 was due, or a 0 that arrived where a 1 was due. The block keeps a saturating count of each category and a third count of all mismatches.

While aligned, the detector measures the error density over fixed windows whose length follows from the selected error-ratio threshold. When the density is too high, it declares alignment lost, stops counting and acquires the stream again on its own. Two loss modes are offered. In the immediate mode, alignment is dropped on the offending bit. In the framed mode, the decision is held until the end of the current window.

Top module: `prbs_err_det`

## Requirements
- R1: `order_sel` picks the sequence length 2^n-1 with recurrence b[t] = b[t-n] XOR b[t-m]. The codes map as follows: code 0 gives n=7, m=6; code 1 gives n=9, m=5; code 2 gives n=11, m=9; code 3 gives n=15, m=14; code 4 gives n=20, m=3; code 5 gives n=23, m=18; code 6 gives n=31, m=28. Code 7 behaves as code 0.
- R2: After reset or after a loss, `sync_lost` is 1. It falls in the cycle after the 2n-th enabled bit when those 2n bits are all free of errors: the first n bits are loaded and the next n are predicted correctly.
- R3: While aligned, a received 1 where 0 was predicted increments `ins_cnt`, and a received 0 where 1 was predicted increments `om_cnt`. Every mismatch increments `tot_cnt`. Each count reaches its output one cycle after the bit.
- R4: All counts are 0 after reset. `cnt_clr` zeroes them on the next cycle, and it wins over an error on the same bit.
- R5: Each counter stops at 2^CNT_W-1 and holds there while further errors arrive.
- R6: No count changes while `sync_lost` is 1.
- R7: The window length is 10^e enabled bits. The first window starts on the first bit after alignment. `thr_sel` = 0 uses e = AUTO_EXP (default 3), and `thr_sel` = c for c in 1..7 uses e = c+1.
- R8: With `frame_mode` = 0, alignment is lost on the bit that brings the window's error count above ERR_ALLOW (default 1). That bit is still counted.
- R9: With `frame_mode` = 1, the error total is judged only on the last bit of each window, and alignment is lost there if the total exceeds ERR_ALLOW.
- R10: Cycles with `bit_en` = 0 change neither the counts, `sync_lost`, nor the alignment.
- R11: After a loss, the block re-acquires from the incoming stream without outside action, even when corrupt bits follow the loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Qualifies `rx_bit` in this cycle |
| rx_bit | input | 1 | Received stream bit |
| order_sel | input | 3 | Sequence order code (R1) |
| frame_mode | input | 1 | 0: immediate loss decision, 1: end-of-window decision |
| thr_sel | input | 3 | Error-ratio threshold code (R7) |
| cnt_clr | input | 1 | Zeroes all counts |
| sync_lost | output | 1 | 1 while not aligned |
| ins_cnt | output | CNT_W | Received-1-for-0 error count |
| om_cnt | output | CNT_W | Received-0-for-1 error count |
| tot_cnt | output | CNT_W | Count of all errors |

## Verification
Two cases can land on the same bit. The first is a counted error together with a counter clear. The bench drives a deliberately flipped bit in the very cycle that `cnt_clr` is high and expects all three counts to read zero, while the window still keeps that error toward its loss decision. The second is the error that triggers an immediate loss: the bench places a second error in one window and expects it to be counted and `sync_lost` to rise in the same cycle. The counts must then stay frozen while corrupt bits disturb re-acquisition.

// File: rtl/prbs_det_pkg.sv
package prbs_det_pkg;
  localparam int MAX_ORD = 31;
  localparam int MAX_EXP = 8;

  typedef enum logic {S_ACQ, S_LOCK} sync_st_e;

  function automatic logic [5:0] ord_len(input logic [2:0] sel);
    case (sel)
      3'd1: return 6'd9;
      3'd2: return 6'd11;
      3'd3: return 6'd15;
      3'd4: return 6'd20;
      3'd5: return 6'd23;
      3'd6: return 6'd31;
      default: return 6'd7;
    endcase
  endfunction

  function automatic logic [5:0] ord_tap(input logic [2:0] sel);
    case (sel)
      3'd1: return 6'd5;
      3'd2: return 6'd9;
      3'd3: return 6'd14;
      3'd4: return 6'd3;
      3'd5: return 6'd18;
      3'd6: return 6'd28;
      default: return 6'd6;
    endcase
  endfunction

  function automatic int unsigned pow10(input int e);
    int unsigned v;
    v = 1;
    for (int i = 0; i < e; i++) v = v * 10;
    return v;
  endfunction
endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
  import prbs_det_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       load_rx,
  input  logic       rx_bit,
  input  logic [2:0] order_sel,
  output logic       pred
);
  logic [MAX_ORD-1:0] ref_q, ref_d;
  logic [4:0]         idx_a, idx_b;

  always_comb begin
    idx_a = 5'(ord_len(order_sel) - 6'd1);
    idx_b = 5'(ord_tap(order_sel) - 6'd1);
    pred  = ref_q[idx_a] ^ ref_q[idx_b];
    ref_d = ref_q;
    if (bit_en) ref_d = {ref_q[MAX_ORD-2:0], load_rx ? rx_bit : pred};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end
endmodule

// File: rtl/prbs_sync_ctrl.sv
module prbs_sync_ctrl
  import prbs_det_pkg::*;
#(
  parameter int ERR_ALLOW = 1,
  parameter int AUTO_EXP  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       mismatch,
  input  logic [2:0] order_sel,
  input  logic [2:0] thr_sel,
  input  logic       frame_mode,
  output logic       locked
);
  localparam int WIN_W = $clog2(pow10(MAX_EXP));
  localparam int ERR_W = $clog2(ERR_ALLOW + 2) + 1;
  localparam logic [ERR_W:0] ALLOW_V = (ERR_W+1)'(ERR_ALLOW);
  localparam logic [ERR_W:0] CAP_V   = (ERR_W+1)'(ERR_ALLOW + 1);

  sync_st_e         st_q, st_d;
  logic [6:0]       acq_q, acq_d, len;
  logic [WIN_W-1:0] win_q, win_d, win_len;
  logic [ERR_W-1:0] err_q, err_d;
  logic [ERR_W:0]   errs_now;
  logic             last, lose;

  always_comb begin
    case (thr_sel)
      3'd0: win_len = WIN_W'(pow10(AUTO_EXP));
      3'd1: win_len = WIN_W'(pow10(2));
      3'd2: win_len = WIN_W'(pow10(3));
      3'd3: win_len = WIN_W'(pow10(4));
      3'd4: win_len = WIN_W'(pow10(5));
      3'd5: win_len = WIN_W'(pow10(6));
      3'd6: win_len = WIN_W'(pow10(7));
      default: win_len = WIN_W'(pow10(8));
    endcase
    len      = {1'b0, ord_len(order_sel)};
    errs_now = {1'b0, err_q} + {{ERR_W{1'b0}}, mismatch};
    last     = (win_q == win_len - 1'b1);
    lose     = frame_mode ? (last && (errs_now > ALLOW_V))
                          : (mismatch && (errs_now > ALLOW_V));
    st_d  = st_q;
    acq_d = acq_q;
    win_d = win_q;
    err_d = err_q;
    if (bit_en) begin
      if (st_q == S_ACQ) begin
        if (acq_q < len)                    acq_d = acq_q + 7'd1;
        else if (mismatch)                  acq_d = len;
        else if (acq_q == (len << 1) - 7'd1) begin
          st_d  = S_LOCK;
          win_d = '0;
          err_d = '0;
        end else                            acq_d = acq_q + 7'd1;
      end else begin
        if (lose) begin
          st_d  = S_ACQ;
          acq_d = '0;
        end else if (last) begin
          win_d = '0;
          err_d = '0;
        end else begin
          win_d = win_q + 1'b1;
          err_d = (errs_now > CAP_V) ? CAP_V[ERR_W-1:0] : errs_now[ERR_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_ACQ;
      acq_q <= '0;
      win_q <= '0;
      err_q <= '0;
    end else begin
      st_q  <= st_d;
      acq_q <= acq_d;
      win_q <= win_d;
      err_q <= err_d;
    end
  end

  assign locked = (st_q == S_LOCK);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)                  q_d = '0;
    else if (inc && q != TOP) q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/prbs_err_det.sv
module prbs_err_det #(
  parameter int CNT_W     = 16,
  parameter int ERR_ALLOW = 1,
  parameter int AUTO_EXP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic [2:0]       order_sel,
  input  logic             frame_mode,
  input  logic [2:0]       thr_sel,
  input  logic             cnt_clr,
  output logic             sync_lost,
  output logic [CNT_W-1:0] ins_cnt,
  output logic [CNT_W-1:0] om_cnt,
  output logic [CNT_W-1:0] tot_cnt
);
  localparam int N_CNT = 3;

  logic [1:0]       rst_sync;
  logic             rst_i, pred, locked, mismatch, count_en;
  logic [N_CNT-1:0] inc_v;
  logic [CNT_W-1:0] cnt_v [N_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  prbs_ref_gen u_ref (
    .clk(clk), .rst_n(rst_i), .bit_en(bit_en), .load_rx(~locked),
    .rx_bit(rx_bit), .order_sel(order_sel), .pred(pred)
  );

  assign mismatch = rx_bit ^ pred;

  prbs_sync_ctrl #(.ERR_ALLOW(ERR_ALLOW), .AUTO_EXP(AUTO_EXP)) u_sync (
    .clk(clk), .rst_n(rst_i), .bit_en(bit_en), .mismatch(mismatch),
    .order_sel(order_sel), .thr_sel(thr_sel), .frame_mode(frame_mode),
    .locked(locked)
  );

  assign count_en = bit_en & locked;
  assign inc_v[0] = count_en & rx_bit & ~pred;
  assign inc_v[1] = count_en & ~rx_bit & pred;
  assign inc_v[2] = count_en & mismatch;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_i), .clr(cnt_clr), .inc(inc_v[g]), .q(cnt_v[g])
    );
  end

  assign ins_cnt   = cnt_v[0];
  assign om_cnt    = cnt_v[1];
  assign tot_cnt   = cnt_v[2];
  assign sync_lost = ~locked;
endmodule

// File: rtl/prbs_err_det_chk.sv
module prbs_err_det_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             cnt_clr,
  input logic             sync_lost,
  input logic [CNT_W-1:0] ins_cnt,
  input logic [CNT_W-1:0] om_cnt,
  input logic [CNT_W-1:0] tot_cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (ins_cnt == '0 && om_cnt == '0 && tot_cnt == '0));

  p_hold_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_cnt == TOP && !cnt_clr) |=> ins_cnt == TOP);

  p_frozen_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lost && !cnt_clr) |=> ($stable(ins_cnt) && $stable(om_cnt) && $stable(tot_cnt)));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !cnt_clr) |=> ($stable(sync_lost) && $stable(tot_cnt) && $stable(ins_cnt)));

  p_tot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (tot_cnt == $past(tot_cnt) || tot_cnt == $past(tot_cnt) + 1'b1));

  p_one_category_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> !(ins_cnt != $past(ins_cnt) && om_cnt != $past(om_cnt)));
endmodule

bind prbs_err_det prbs_err_det_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cnt_clr(cnt_clr),
  .sync_lost(sync_lost), .ins_cnt(ins_cnt), .om_cnt(om_cnt), .tot_cnt(tot_cnt)
);

// File: tb/tb_prbs_err_det.sv
module tb_prbs_err_det;
  localparam int CW  = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n, bit_en, rx_bit, frame_mode, cnt_clr;
  logic [2:0]    order_sel, thr_sel;
  logic          sync_lost;
  logic [CW-1:0] ins_cnt, om_cnt, tot_cnt;

  prbs_err_det #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .order_sel(order_sel), .frame_mode(frame_mode), .thr_sel(thr_sel),
    .cnt_clr(cnt_clr), .sync_lost(sync_lost), .ins_cnt(ins_cnt),
    .om_cnt(om_cnt), .tot_cnt(tot_cnt)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R2";

  int nt[7] = '{7, 9, 11, 15, 20, 23, 31};
  int mt[7] = '{6, 5, 9, 14, 3, 18, 28};
  int n, m, wlen;
  logic [63:0] hs;
  bit lk, clean;
  int acq_k, pos, werr, ie, oe, te;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic peek();
    return hs[n-1] ^ hs[m-1];
  endfunction

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic check_all();
    if (clean || lk) chk("sync_lost", sync_lost, lk ? 0 : 1);
    chk("ins_cnt", ins_cnt, ie);
    chk("om_cnt", om_cnt, oe);
    chk("tot_cnt", tot_cnt, te);
  endtask

  task automatic step(input logic flip, input logic clr);
    logic e;
    int en_;
    bit last, lose;
    e = peek();
    @(negedge clk);
    bit_en = 1'b1; rx_bit = e ^ flip; cnt_clr = clr;
    hs = {hs[62:0], e};
    if (lk) begin
      if (clr) begin ie = 0; oe = 0; te = 0; end
      else if (flip) begin
        if (!e) ie = sat(ie + 1); else oe = sat(oe + 1);
        te = sat(te + 1);
      end
      en_  = werr + int'(flip);
      last = (pos == wlen - 1);
      lose = frame_mode ? (last && en_ > 1) : (flip && en_ > 1);
      if (lose) begin lk = 0; acq_k = 0; clean = 1; end
      else if (last) begin pos = 0; werr = 0; end
      else begin pos++; werr = (en_ > 2) ? 2 : en_; end
    end else begin
      if (clr) begin ie = 0; oe = 0; te = 0; end
      if (flip) clean = 0;
      acq_k++;
      if (clean && acq_k == 2 * n) begin lk = 1; pos = 0; werr = 0; end
    end
    @(posedge clk); #2;
    bit_en = 1'b0; cnt_clr = 1'b0;
    check_all();
  endtask

  task automatic do_reset(input int code, input logic fm, input logic [2:0] th);
    order_sel = 3'(code); frame_mode = fm; thr_sel = th;
    n = nt[code]; m = mt[code];
    wlen = (th == 3'd0) ? 1000 : 10 ** (int'(th) + 1);
    hs = '1; lk = 0; clean = 1; acq_k = 0; pos = 0; werr = 0;
    ie = 0; oe = 0; te = 0;
    bit_en = 0; cnt_clr = 0; rx_bit = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    tag = "R4";
    check_all();
  endtask

  task automatic lock_clean();
    while (!lk) step(1'b0, 1'b0);
  endtask

  task automatic lock_dirty();
    for (int i = 0; i < 200; i++) begin
      step(1'b0, 1'b0);
      if (!sync_lost) break;
    end
    chk("relock sync_lost", sync_lost, 0);
    lk = 1; clean = 1; pos = 0; werr = 0;
  endtask

  task automatic next_window();
    step(1'b0, 1'b0);
    while (pos != 0) step(1'b0, 1'b0);
  endtask

  task automatic err_near(input logic want, input int minpos, input logic clr);
    while (!(pos >= minpos && peek() == want)) step(1'b0, 1'b0);
    step(1'b1, clr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1, R2: every order locks after exactly 2n clean bits and stays clean
    for (int c = 0; c < 7; c++) begin
      do_reset(c, 1'b0, 3'd1);
      tag = "R1";
      for (int i = 0; i < 2 * nt[c] + 40; i++) step(1'b0, 1'b0);
      chk("R2 locked after 2n", sync_lost, 0);
    end

    // R3, R7, R8: one error per window is tolerated, a second in one window drops sync
    do_reset(0, 1'b0, 3'd1);
    tag = "R2";
    lock_clean();
    tag = "R3";
    err_near(1'b0, 10, 1'b0);
    next_window();
    err_near(1'b1, 10, 1'b0);
    chk("R3 ins", ins_cnt, 1);
    chk("R3 om", om_cnt, 1);
    tag = "R7";
    for (int i = 0; i < 100; i++) step(1'b0, 1'b0);
    tag = "R8";
    next_window();
    err_near(1'b0, 10, 1'b0);
    err_near(1'b1, 20, 1'b0);
    chk("R8 lost on second error", sync_lost, 1);

    // R6, R11: corrupt bits while unsynchronised are not counted; relock follows
    tag = "R6";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    tag = "R11";
    lock_dirty();

    // R4: clear and a counted error on the same bit
    tag = "R4";
    next_window();
    err_near(1'b1, 10, 1'b1);
    chk("R4 clear wins", tot_cnt, 0);
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0);

    // R10: idle cycles with garbage on the data line
    tag = "R10";
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); bit_en = 1'b0; rx_bit = 1'(i); cnt_clr = 1'b0;
      @(posedge clk); #2;
      check_all();
    end
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0);

    // R9, R7: framed mode with automatic threshold (1000-bit windows)
    do_reset(0, 1'b1, 3'd0);
    tag = "R9";
    lock_clean();
    err_near(1'b0, 10, 1'b0);
    err_near(1'b1, 20, 1'b0);
    chk("R9 held until window end", sync_lost, 0);
    while (lk) step(1'b0, 1'b0);
    chk("R9 lost at window end", sync_lost, 1);
    lock_clean();

    // R5: saturation of the counters
    do_reset(1, 1'b0, 3'd1);
    tag = "R5";
    lock_clean();
    for (int i = 0; i < 18; i++) begin
      next_window();
      err_near(1'b0, 10, 1'b0);
    end
    chk("R5 ins saturated", ins_cnt, MAXC);
    next_window();
    err_near(1'b1, 10, 1'b0);
    chk("R5 tot saturated", tot_cnt, MAXC);
    chk("R5 om counted", om_cnt, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule